// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block takes an incoming frame as a stream of bytes, appends a 4-byte Ethernet CRC-32, and stores the result in one or more receive buffers. Each buffer is described by an 8-byte descriptor that sits in a ring in memory. The first descriptor word holds a 16-bit flag field in bits 31:16 and a 16-bit length in bits 15:0. The second word holds the byte address of the buffer. A buffer is filled up to the configured maximum buffer size. Its descriptor is then written back with the length, with the empty bit cleared and, on the final buffer of the frame, with the last bit and any error flags set.

The engine keeps a receive-active status. This status is true only when the descriptor at the ring pointer is marked empty. While the status is false, the engine holds off the byte stream. Software loads the ring pointer from the ring base with a one-cycle init pulse. It re-checks the current descriptor with a kick pulse after handing buffers back. On every descriptor write-back the engine pulses one event: a buffer event for an intermediate buffer, a frame event for the closing one. The CRC of incoming data is not checked.

Top module: `rxr_engine`

## Requirements
- R1: After reset, rx_active, in_ready, mem_req, ev_buf and ev_frame are all 0.
- R2: ring_init loads the ring pointer from ring_base and clears rx_active. A kick while inactive reads the descriptor at the pointer and sets rx_active to its empty bit (flag bit 15, word bit 31).
- R3: The stored byte sequence is the accepted payload followed by the CRC-32 (reflected, polynomial 0xEDB88320, initial all ones, final inversion) of all payload bytes, most significant byte first. Data bytes are written one per access with a single byte enable.
- R4: Each buffer holds the smaller of the bytes still to be stored and the maximum buffer size. The maximum buffer size is max_buf_cfg with only bits 13:4 kept.
- R5: When the CRC does not fit in a buffer, its leading bytes end that buffer and the remaining bytes start the next one.
- R6: If payload length plus 4 exceeds MAX_FRAME, only the first MAX_FRAME-4 payload bytes are stored. The final descriptor then gets the truncated flag (bit 0) and the length-violation flag (bit 5).
- R7: If the stored size (after clamping) exceeds frame_limit, the final descriptor gets the length-violation flag (bit 5).
- R8: Write-back puts the buffer length in bits 15:0 and the flags in bits 31:16. It clears the empty bit, keeps every other flag bit, and sets the last bit (bit 11) and the error flags only on the frame's final buffer.
- R9: A write-back of a non-final buffer pulses ev_buf, and a write-back of the final buffer pulses ev_frame, in the same cycle as the write. Both never pulse together.
- R10: After a write-back, the pointer becomes ring_base if the wrap flag (bit 13) was set, and the old pointer plus 8 otherwise.
- R11: If a descriptor without the empty bit is reached mid-frame, the rest of the frame is consumed and discarded. No further write-back or frame event occurs, and the pointer stays on that descriptor.
- R12: After each frame, rx_active equals the empty bit of the descriptor at the pointer. While rx_active is 0 and the engine is idle, in_ready and mem_req stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the last payload byte of a frame |
| in_ready | output | 1 | Engine accepts the byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_be | output | 4 | Byte enables for writes |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| max_buf_cfg | input | 16 | Maximum buffer size, bits 13:4 used |
| frame_limit | input | 16 | Frame length limit in bytes |
| ring_base | input | AW | Byte address of the first descriptor |
| ring_init | input | 1 | Load pointer from ring_base |
| rx_kick | input | 1 | Re-check the descriptor at the pointer |
| rx_active | output | 1 | Next descriptor is empty |
| ev_buf | output | 1 | Intermediate buffer completed |
| ev_frame | output | 1 | Frame completed |

## Verification
The assertions assume that the masked maximum buffer size is at least 16 and that it stays constant while a frame is in progress. They also assume that memory returns read data exactly one cycle after a read request, and that ring_init and rx_kick arrive only while the engine is idle. The stimulus respects this by changing configuration and re-arming descriptors only after a settling gap that follows each frame. It also uses masked buffer sizes of 32 and 64 and a memory model with fixed one-cycle read latency.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD0,
        ST_RD1,
        ST_RDW,
        ST_DATA,
        ST_WB,
        ST_DROP,
        ST_CHK,
        ST_CHKW
    } rxr_state_e;

    localparam int FL_EMPTY   = 15;
    localparam int FL_WRAP    = 13;
    localparam int FL_LAST    = 11;
    localparam int FL_LENERR  = 5;
    localparam int FL_TRUNC   = 0;
    localparam int DESC_BYTES = 8;
    localparam logic [15:0] MBS_MASK = 16'h3FF0;

    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ 32'hEDB88320;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rxr_crc32.sv
module rxr_crc32 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc_val
);
    import rxr_pkg::*;

    logic [31:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr)     crc_d = 32'hFFFF_FFFF;
        else if (en) crc_d = crc32_step(crc_q, din);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= 32'hFFFF_FFFF;
        else        crc_q <= crc_d;
    end

    assign crc_val = ~crc_q;

    // R3: a clear leaves the accumulator at its seed value
    p_crc_seed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_q == 32'hFFFF_FFFF));

endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
    parameter int AW   = 32,
    parameter int STEP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic [AW-1:0] base,
    input  logic          adv,
    input  logic          wrap,
    output logic [AW-1:0] ptr
);
    logic [AW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (init)      ptr_d = base;
        else if (adv)  ptr_d = wrap ? base : ptr_q + AW'(STEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // R10: an advance lands either on the base or one descriptor further
    p_ptr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !init) |=> ((ptr_q == $past(base)) || (ptr_q == $past(ptr_q) + AW'(STEP))));

    // R11: without advance or init the pointer does not move
    p_ptr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !init) |=> $stable(ptr_q));

endmodule

// File: rtl/rxr_engine.sv
module rxr_engine #(
    parameter int AW        = 32,
    parameter int MAX_FRAME = 2048
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic          in_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [3:0]    mem_be,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic [15:0]   max_buf_cfg,
    input  logic [15:0]   frame_limit,
    input  logic [AW-1:0] ring_base,
    input  logic          ring_init,
    input  logic          rx_kick,
    output logic          rx_active,
    output logic          ev_buf,
    output logic          ev_frame
);
    import rxr_pkg::*;

    localparam int CW          = $clog2(MAX_FRAME + 1);
    localparam int PAYLOAD_CAP = MAX_FRAME - 4;

    typedef struct packed {
        rxr_state_e    st;
        logic [15:0]   fl;
        logic [AW-1:0] ba;
        logic [15:0]   blen;
        logic [CW-1:0] tot;
        logic          crcph;
        logic [1:0]    cidx;
        logic          indone;
        logic          tr;
        logic          fin;
        logic          act;
    } ctl_t;

    ctl_t s_d, s_q;

    logic [AW-1:0] ptr;
    logic          ptr_adv;
    logic          ptr_wrap;
    logic          crc_clr;
    logic          crc_en;
    logic [31:0]   crc_val;
    logic [15:0]   mbs_eff;
    logic          byte_wr;
    logic [7:0]    wr_byte;
    logic          fin_now;
    logic          lenerr;
    logic [15:0]   wb_flags;
    logic [AW-1:0] byte_addr;

    rxr_crc32 i_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (crc_clr),
        .en      (crc_en),
        .din     (in_data),
        .crc_val (crc_val)
    );

    rxr_ring_ptr #(.AW(AW), .STEP(DESC_BYTES)) i_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (ring_init),
        .base  (ring_base),
        .adv   (ptr_adv),
        .wrap  (ptr_wrap),
        .ptr   (ptr)
    );

    assign mbs_eff   = max_buf_cfg & MBS_MASK;
    assign byte_addr = s_q.ba + AW'(s_q.blen);
    assign lenerr    = s_q.tr || (32'(s_q.tot) > 32'(frame_limit));

    always_comb begin
        wb_flags = s_q.fl & ~(16'h1 << FL_EMPTY);
        if (s_q.fin) begin
            wb_flags[FL_LAST]   = 1'b1;
            wb_flags[FL_LENERR] = lenerr;
            wb_flags[FL_TRUNC]  = s_q.tr;
        end
    end

    always_comb begin
        s_d       = s_q;
        in_ready  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_be    = 4'h0;
        mem_addr  = ptr;
        mem_wdata = 32'h0;
        ev_buf    = 1'b0;
        ev_frame  = 1'b0;
        ptr_adv   = 1'b0;
        ptr_wrap  = 1'b0;
        crc_clr   = 1'b0;
        crc_en    = 1'b0;
        byte_wr   = 1'b0;
        wr_byte   = 8'h0;
        fin_now   = 1'b0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (rx_kick && !s_q.act) begin
                    s_d.st = ST_CHK;
                end else if (s_q.act && in_valid) begin
                    s_d.st     = ST_RD0;
                    s_d.tot    = '0;
                    s_d.crcph  = 1'b0;
                    s_d.cidx   = 2'd0;
                    s_d.indone = 1'b0;
                    s_d.tr     = 1'b0;
                    s_d.fin    = 1'b0;
                    crc_clr    = 1'b1;
                end
            end
            ST_RD0: begin
                mem_req  = 1'b1;
                mem_addr = ptr;
                s_d.st   = ST_RD1;
            end
            ST_RD1: begin
                s_d.fl   = mem_rdata[31:16];
                s_d.blen = 16'd0;
                if (!mem_rdata[16 + FL_EMPTY]) begin
                    s_d.st = s_q.indone ? ST_CHK : ST_DROP;
                end else begin
                    mem_req  = 1'b1;
                    mem_addr = ptr + AW'(4);
                    s_d.st   = ST_RDW;
                end
            end
            ST_RDW: begin
                s_d.ba = mem_rdata[AW-1:0];
                s_d.st = ST_DATA;
            end
            ST_DATA: begin
                if (!s_q.crcph) begin
                    in_ready = 1'b1;
                    if (in_valid) begin
                        crc_en = 1'b1;
                        if (int'(s_q.tot) < PAYLOAD_CAP) begin
                            byte_wr = 1'b1;
                            wr_byte = in_data;
                        end else begin
                            s_d.tr = 1'b1;
                        end
                        if (in_last) begin
                            s_d.crcph  = 1'b1;
                            s_d.indone = 1'b1;
                        end
                    end
                end else begin
                    byte_wr = 1'b1;
                    case (s_q.cidx)
                        2'd0:    wr_byte = crc_val[31:24];
                        2'd1:    wr_byte = crc_val[23:16];
                        2'd2:    wr_byte = crc_val[15:8];
                        default: wr_byte = crc_val[7:0];
                    endcase
                    s_d.cidx = s_q.cidx + 2'd1;
                    fin_now  = (s_q.cidx == 2'd3);
                end
                if (byte_wr) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = byte_addr;
                    mem_be    = 4'b0001 << byte_addr[1:0];
                    mem_wdata = {4{wr_byte}};
                    s_d.blen  = s_q.blen + 16'd1;
                    s_d.tot   = s_q.tot + CW'(1);
                    if (fin_now || ((s_q.blen + 16'd1) == mbs_eff)) begin
                        s_d.st  = ST_WB;
                        s_d.fin = fin_now;
                    end
                end
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = 4'hF;
                mem_addr  = ptr;
                mem_wdata = {wb_flags, s_q.blen};
                ev_buf    = !s_q.fin;
                ev_frame  = s_q.fin;
                ptr_adv   = 1'b1;
                ptr_wrap  = s_q.fl[FL_WRAP];
                s_d.st    = s_q.fin ? ST_CHK : ST_RD0;
            end
            ST_DROP: begin
                if (s_q.indone) begin
                    s_d.st = ST_CHK;
                end else begin
                    in_ready = 1'b1;
                    if (in_valid && in_last) begin
                        s_d.indone = 1'b1;
                        s_d.st     = ST_CHK;
                    end
                end
            end
            ST_CHK: begin
                mem_req  = 1'b1;
                mem_addr = ptr;
                s_d.st   = ST_CHKW;
            end
            ST_CHKW: begin
                s_d.act = mem_rdata[16 + FL_EMPTY];
                s_d.st  = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (ring_init) s_d.act = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, fl: '0, ba: '0, blen: '0, tot: '0, crcph: 1'b0,
                     cidx: '0, indone: 1'b0, tr: 1'b0, fin: 1'b0, act: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_active = s_q.act;

    // R4: a buffer never holds more than the masked maximum size
    p_buf_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DATA) |-> (s_q.blen < mbs_eff));

    // R6: the stored byte count never passes the frame cap
    p_total_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(s_q.tot) <= 32'(MAX_FRAME)));

    // R3: data writes touch exactly one byte lane
    p_byte_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && (mem_be != 4'hF)) |-> ($countones(mem_be) == 1));

    // R9: events come only with a descriptor write and never both
    p_event_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_buf || ev_frame) |-> (mem_req && mem_we && (mem_be == 4'hF)));
    p_single_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_buf && ev_frame));

    // R12: no input handshake without an empty descriptor, no access while parked
    p_ready_active_r12: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> rx_active);
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_active && (s_q.st == ST_IDLE)) |-> !mem_req);

endmodule

// File: tb/test_rxr_engine.sv
module test_rxr_engine;

    localparam int AW     = 32;
    localparam int MAXF   = 256;
    localparam int NDESC  = 8;
    localparam int BUFBAS = 256;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, in_last, in_ready;
    logic [7:0]    in_data;
    logic          mem_req, mem_we;
    logic [3:0]    mem_be;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;
    logic [15:0]   max_buf_cfg, frame_limit;
    logic [AW-1:0] ring_base;
    logic          ring_init, rx_kick, rx_active, ev_buf, ev_frame;

    always #4 clk = ~clk;

    rxr_engine #(.AW(AW), .MAX_FRAME(MAXF)) i_rxr_engine (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .max_buf_cfg(max_buf_cfg), .frame_limit(frame_limit), .ring_base(ring_base),
        .ring_init(ring_init), .rx_kick(rx_kick), .rx_active(rx_active),
        .ev_buf(ev_buf), .ev_frame(ev_frame)
    );

    logic [7:0] mem [0:1023];

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[{mem_addr[9:2], 2'b00} + b] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= {mem[{mem_addr[9:2], 2'b11}], mem[{mem_addr[9:2], 2'b10}],
                              mem[{mem_addr[9:2], 2'b01}], mem[{mem_addr[9:2], 2'b00}]};
            end
        end
    end

    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    logic [63:0] exp_desc[$];
    bit          exp_ev[$];
    int          exp_da[$];
    logic [7:0]  exp_dv[$];
    logic [7:0]  payload[$];
    int          model_ptr;

    // Reference comparison on every clock: descriptor writes and events
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && mem_we && mem_be == 4'hF) begin
                if (exp_desc.size() == 0) begin
                    chk(1'b0, "R8/R11 unexpected descriptor write", {32'(mem_addr), mem_wdata}, 64'h0);
                end else begin
                    logic [63:0] e;
                    e = exp_desc.pop_front();
                    chk({32'(mem_addr), mem_wdata} == e, "R8/R10 descriptor write", {32'(mem_addr), mem_wdata}, e);
                end
            end
            if (ev_buf || ev_frame) begin
                if (exp_ev.size() == 0) begin
                    chk(1'b0, "R9/R11 unexpected event", {62'h0, ev_buf, ev_frame}, 64'h0);
                end else begin
                    bit f;
                    f = exp_ev.pop_front();
                    chk(ev_frame == f && ev_buf == !f, "R9 event kind", {62'h0, ev_buf, ev_frame}, {62'h0, !f, f});
                end
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog act=%0d exp=0", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [15:0] rd16(input int a);
        return {mem[a+1], mem[a]};
    endfunction

    function automatic logic [31:0] rd32(input int a);
        return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
    endfunction

    task automatic arm_all();
        for (int i = 0; i < NDESC; i++) begin
            logic [15:0] f;
            logic [31:0] ba;
            f = 16'h8000;
            if (i == NDESC - 1) f[13] = 1'b1;
            if (i % 2 == 1) f[12] = 1'b1;
            ba = BUFBAS + i * 64;
            mem[i*8+0] = 8'h00; mem[i*8+1] = 8'h00;
            mem[i*8+2] = f[7:0]; mem[i*8+3] = f[15:8];
            for (int b = 0; b < 4; b++) mem[i*8+4+b] = ba[8*b +: 8];
        end
    endtask

    task automatic pulse_kick();
        @(negedge clk); rx_kick = 1'b1;
        @(negedge clk); rx_kick = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // Behavioural model: predicts descriptor writes, events, data and status
    task automatic model(output bit exp_act);
        int n, keep, size, idx, p, mbs, visited[$];
        bit tr, lg, dropped;
        logic [31:0] c;
        logic [7:0] stream[$];
        n = payload.size();
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 8; k++) begin
                bit lsb;
                lsb = c[0] ^ payload[i][k];
                c = c >> 1;
                if (lsb) c = c ^ 32'hEDB88320;
            end
        end
        c = ~c;
        keep = (n < MAXF - 4) ? n : MAXF - 4;
        tr = (n > MAXF - 4);
        for (int i = 0; i < keep; i++) stream.push_back(payload[i]);
        stream.push_back(c[31:24]); stream.push_back(c[23:16]);
        stream.push_back(c[15:8]);  stream.push_back(c[7:0]);
        size = keep + 4;
        lg = tr || (size > int'(frame_limit));
        mbs = int'(max_buf_cfg & 16'h3FF0);
        idx = 0; p = model_ptr; dropped = 1'b0;
        while (idx < size) begin
            logic [15:0] fl, nf;
            bit seen, fin;
            int ba, bl;
            fl = rd16(p + 2);
            seen = 1'b0;
            foreach (visited[v]) if (visited[v] == p) seen = 1'b1;
            if (!fl[15] || seen) begin dropped = 1'b1; break; end
            ba = int'(rd32(p + 4));
            bl = (size - idx < mbs) ? size - idx : mbs;
            for (int j = 0; j < bl; j++) begin exp_da.push_back(ba + j); exp_dv.push_back(stream[idx + j]); end
            idx += bl;
            fin = (idx == size);
            nf = fl & 16'h7FFF;
            if (fin) begin nf[11] = 1'b1; nf[5] = lg; nf[0] = tr; end
            exp_desc.push_back({32'(p), nf, 16'(bl)});
            exp_ev.push_back(fin);
            visited.push_back(p);
            p = fl[13] ? int'(ring_base) : p + 8;
        end
        model_ptr = p;
        if (dropped) exp_act = 1'b0;
        else begin
            bit seen2;
            seen2 = 1'b0;
            foreach (visited[v]) if (visited[v] == p) seen2 = 1'b1;
            exp_act = rd16(p + 2) >> 15 & !seen2;
        end
    endtask

    task automatic run_frame(input int n, input string tag);
        bit exp_act;
        int bad, first_a;
        logic [7:0] fa, fe;
        for (int a = BUFBAS; a < BUFBAS + NDESC * 64; a++) mem[a] = 8'h00;
        payload.delete();
        for (int i = 0; i < n; i++) payload.push_back(8'((n * 7 + i * 13 + 5) & 255));
        model(exp_act);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = payload[i]; in_last = (i == n - 1);
            #1;
            while (!in_ready) begin @(negedge clk); #1; end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        repeat (40) @(negedge clk);
        bad = 0; first_a = 0; fa = 0; fe = 0;
        foreach (exp_da[k]) begin
            if (mem[exp_da[k]] !== exp_dv[k]) begin
                if (bad == 0) begin first_a = exp_da[k]; fa = mem[exp_da[k]]; fe = exp_dv[k]; end
                bad++;
            end
        end
        chk(bad == 0, {tag, " R3/R4/R5 stored bytes at ", $sformatf("%0h", first_a)}, 64'(fa), 64'(fe));
        chk(exp_desc.size() == 0, {tag, " R8 missing descriptor writes"}, 64'(exp_desc.size()), 0);
        chk(exp_ev.size() == 0, {tag, " R9 missing events"}, 64'(exp_ev.size()), 0);
        chk(rx_active == exp_act, {tag, " R12 rx_active after frame"}, 64'(rx_active), 64'(exp_act));
        exp_da.delete(); exp_dv.delete(); exp_desc.delete(); exp_ev.delete();
    endtask

    initial begin
        int nxt;
        for (int a = 0; a < 1024; a++) mem[a] = 8'h00;
        rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h0; in_last = 1'b0;
        max_buf_cfg = 16'h0040; frame_limit = 16'd1518; ring_base = '0;
        ring_init = 1'b0; rx_kick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rx_active == 0, "R1 rx_active", 64'(rx_active), 0);
        chk(in_ready == 0, "R1 in_ready", 64'(in_ready), 0);
        chk(mem_req == 0 && ev_buf == 0 && ev_frame == 0, "R1 quiet outputs",
            {61'h0, mem_req, ev_buf, ev_frame}, 0);

        ring_init = 1'b1; @(negedge clk); ring_init = 1'b0;
        model_ptr = 0;
        pulse_kick();
        chk(rx_active == 0, "R2 kick on non-empty descriptor", 64'(rx_active), 0);
        arm_all();
        pulse_kick();
        chk(rx_active == 1, "R2 kick on empty descriptor", 64'(rx_active), 1);

        arm_all(); run_frame(10,  "single buffer");
        arm_all(); run_frame(100, "two buffers");
        arm_all(); run_frame(62,  "R5 crc split");
        arm_all(); run_frame(60,  "exact fill");
        frame_limit = 16'd50;
        arm_all(); run_frame(50,  "R7 limit");
        frame_limit = 16'd1518;
        arm_all(); run_frame(300, "R6 truncation");
        max_buf_cfg = 16'h402F;
        arm_all(); run_frame(70,  "R4 masked size");
        max_buf_cfg = 16'h0040;
        arm_all(); run_frame(64,  "R10 wrap");

        // R11: second descriptor of the frame is not empty
        arm_all();
        nxt = (model_ptr == (NDESC - 1) * 8) ? 0 : model_ptr + 8;
        mem[nxt + 3] = mem[nxt + 3] & 8'h7F;
        run_frame(100, "R11 drop");
        chk(mem[BUFBAS + (nxt / 8) * 64] == 8'h00, "R11 dropped buffer untouched",
            64'(mem[BUFBAS + (nxt / 8) * 64]), 0);
        chk(model_ptr == nxt, "R11 pointer parked", 64'(model_ptr), 64'(nxt));

        // R12: inactive engine holds the stream off
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'hA5; in_last = 1'b1;
        for (int i = 0; i < 10; i++) begin
            #1;
            chk(in_ready == 0 && mem_req == 0, "R12 held off while inactive",
                {62'h0, in_ready, mem_req}, 0);
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;

        arm_all();
        pulse_kick();
        chk(rx_active == 1, "R2 re-kick after re-arm", 64'(rx_active), 1);
        arm_all(); run_frame(20, "R11 resume at parked descriptor");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule